// File: doc/BRIEF.md
# Address-Selected Accumulator Arithmetic Unit

This block is the arithmetic unit of a processor whose only instruction is a move from one address to another. It sits in the data address space and takes up eight consecutive word addresses. A write to one of those addresses picks an operation by its address alone. The operation combines the written word with an internal accumulator, and the result updates the accumulator and four status flags: negative (N), zero (Z), signed overflow (V) and carry (C).

A read from the same eight addresses does something different. One address returns the accumulator. The other seven return the outcome of a condition test, encoded as 2 for true and 0 for false. A program adds that value into the low bits of a jump target, so a single move selects one of two adjacent instruction slots, each two words wide. Instruction sequencing and memory are handled outside this block.

The data path is 16 bits wide by default. Read data is combinational from the registered state. A read in the same cycle as a write therefore returns the state from before that write.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator is 0 and N, Z, V and C are all clear, so every condition read at offsets 1 to 7 returns 0 and the accumulator read returns 0.
- R2: Only the addresses BASE to BASE+7 are decoded (BASE = 8, offset = address bits 2:0). A write to any other address changes neither the accumulator nor the flags. A read from any other address returns 0.
- R3: A write at offset 0 loads the data into the accumulator. It sets N from the result's top bit and sets Z when the result is zero. It clears V and C.
- R4: A write at offset 1 computes accumulator minus data, and a write at offset 2 computes data minus accumulator. For both, C is 1 when no borrow occurs (minuend ≥ subtrahend, unsigned) and V flags two's-complement overflow.
- R5: A write at offset 3 adds the data to the accumulator, and a write at offset 4 also adds the current C. For both, C is the carry out and V flags two's-complement overflow.
- R6: A write at offset 5 ORs the data into the accumulator and a write at offset 6 ANDs it. Both set N and Z from the result and clear V and C.
- R7: A write at offset 7 loads the data shifted right by one, with a 0 entering the top bit. It sets C to data bit 0, clears V, and sets N and Z from the result.
- R8: A read at offset 0 returns the accumulator.
- R9: A read at offsets 1 to 7 tests, in that order: N, Z, V, C, N xor V, (N xor V) or Z, and C and not Z. The result is the value 2 (bit 1 set) when the test is true and 0 when it is false.
- R10: While the read strobe is low, the read data is 0.
- R11: A read and a write in the same cycle return the accumulator and flags from before the write. The write then takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (16) | Word address |
| bus_wdata | input | DW (16) | Write data |
| bus_wr | input | 1 | Write strobe; the operation takes effect at the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (16) | Read data: the accumulator or an encoded condition |

## Verification
Read data depends combinationally on the address and the registered state, so a read result is due in the same cycle as its strobe. The bench samples it one time unit after driving the inputs on the falling edge. A write takes effect at the next rising edge, and its effect first appears in a read driven on the following falling edge. The bench advances its own accumulator and flag model only after that rising edge has passed. This ordering lets a read and a write in one cycle be compared against the model's state from before the write.

// File: rtl/acc_alu_unit.sv
module acc_alu_unit #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata
);
  localparam int OFFW = 3;
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic [DW-1:0] acc;
  logic fn, fz, fv, fc;

  wire hit = (bus_addr[AW-1:OFFW] == BASE_A[AW-1:OFFW]);
  wire [OFFW-1:0] off = bus_addr[OFFW-1:0];
  wire wr_hit = bus_wr && hit;

  logic [DW-1:0] opa, opb, res;
  logic          cin, nv, nc, tst;
  logic [DW:0]   sum;

  always_comb begin
    opa = acc;
    opb = bus_wdata;
    cin = 1'b0;
    case (off)
      3'd1: begin opa = acc;       opb = ~bus_wdata; cin = 1'b1; end
      3'd2: begin opa = bus_wdata; opb = ~acc;       cin = 1'b1; end
      3'd4: cin = fc;
      default: ;
    endcase
    sum = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
  end

  wire arith = (off >= 3'd1) && (off <= 3'd4);
  wire ovf   = (opa[DW-1] == opb[DW-1]) && (sum[DW-1] != opa[DW-1]);

  always_comb begin
    case (off)
      3'd0:    res = bus_wdata;
      3'd5:    res = acc | bus_wdata;
      3'd6:    res = acc & bus_wdata;
      3'd7:    res = {1'b0, bus_wdata[DW-1:1]};
      default: res = sum[DW-1:0];
    endcase
    nc = arith ? sum[DW] : (off == 3'd7) ? bus_wdata[0] : 1'b0;
    nv = arith ? ovf : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      fn  <= 1'b0;
      fz  <= 1'b0;
      fv  <= 1'b0;
      fc  <= 1'b0;
    end else if (wr_hit) begin
      acc <= res;
      fn  <= res[DW-1];
      fz  <= (res == '0);
      fv  <= nv;
      fc  <= nc;
    end
  end

  always_comb begin
    case (off)
      3'd1:    tst = fn;
      3'd2:    tst = fz;
      3'd3:    tst = fv;
      3'd4:    tst = fc;
      3'd5:    tst = fn ^ fv;
      3'd6:    tst = (fn ^ fv) | fz;
      3'd7:    tst = fc & ~fz;
      default: tst = 1'b0;
    endcase
  end

  assign bus_rdata = !(bus_rd && hit) ? '0 :
                     (off == 3'd0)    ? acc :
                     {{(DW-2){1'b0}}, tst, 1'b0};

  // R2
  a_r2_miss_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(acc) && $stable({fn, fz, fv, fc})));

  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd0) |=> (acc == $past(bus_wdata) && !fv && !fc));

  // R6
  a_r6_logic_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (off == 3'd5 || off == 3'd6)) |=> (!fv && !fc));

  // R5
  a_r5_add: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd3) |=> (acc == $past(acc) + $past(bus_wdata)));

  // R9
  a_r9_cond_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && off != 3'd0) |-> (bus_rdata == DW'(0) || bus_rdata == DW'(2)));

  // R10
  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R7
  a_r7_shift_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd7) |=> (!acc[DW-1] && fc == $past(bus_wdata[0])));
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;

  int nvec = 0, nbad = 0;
  bit done = 0;

  int m_acc;
  bit m_n, m_z, m_v, m_c;

  always #4 clk = ~clk;

  acc_alu_unit u_acc_alu_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic int sgn(int x);
    return (x >= 32768) ? x - 65536 : x;
  endfunction

  function automatic int exp_read(int a, bit rd);
    bit t;
    if (!rd || a < 8 || a > 15) return 0;
    case (a - 8)
      0: return m_acc;
      1: t = m_n;
      2: t = m_z;
      3: t = m_v;
      4: t = m_c;
      5: t = m_n ^ m_v;
      6: t = (m_n ^ m_v) | m_z;
      default: t = m_c & !m_z;
    endcase
    return t ? 2 : 0;
  endfunction

  task automatic model_write(int a, int d);
    int r, s;
    bit nv, nc;
    if (a < 8 || a > 15) return;
    nv = 0; nc = 0;
    case (a - 8)
      0: r = d;
      1: begin r = m_acc - d; nc = (m_acc >= d); s = sgn(m_acc) - sgn(d); nv = (s > 32767 || s < -32768); end
      2: begin r = d - m_acc; nc = (d >= m_acc); s = sgn(d) - sgn(m_acc); nv = (s > 32767 || s < -32768); end
      3: begin r = m_acc + d; nc = (r > 65535); s = sgn(m_acc) + sgn(d); nv = (s > 32767 || s < -32768); end
      4: begin r = m_acc + d + int'(m_c); nc = (r > 65535); s = sgn(m_acc) + sgn(d) + int'(m_c); nv = (s > 32767 || s < -32768); end
      5: r = m_acc | d;
      6: r = m_acc & d;
      default: begin r = d / 2; nc = d[0]; end
    endcase
    r = r & 32'hFFFF;
    m_acc = r;
    m_n = (r >= 32768);
    m_z = (r == 0);
    m_v = nv;
    m_c = nc;
  endtask

  task automatic apply(int a, int d, bit wr, bit rd, string tag);
    int e;
    @(negedge clk);
    bus_addr = AW'(a);
    bus_wdata = DW'(d);
    bus_wr = wr;
    bus_rd = rd;
    #1;
    e = exp_read(a, rd);
    nvec++;
    if (int'(bus_rdata) != e) begin
      nbad++;
      $display("FAIL %s addr=%0d got=%0h exp=%0h", tag, a, bus_rdata, e);
    end
    @(posedge clk);
    #1;
    if (wr) model_write(a, d);
  endtask

  task automatic rd_all(string tag);
    for (int k = 8; k < 16; k++) apply(k, 0, 0, 1, tag);
  endtask

  initial begin
    m_acc = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    rd_all("R1");
    apply(8, 16'h7FFF, 1, 0, "R3");
    apply(11, 1, 1, 0, "R5");
    rd_all("R5");
    apply(8, 5, 1, 0, "R3");
    apply(9, 7, 1, 0, "R4");
    rd_all("R4");
    apply(10, 3, 1, 0, "R4");
    rd_all("R4");
    apply(8, 16'h8000, 1, 0, "R3");
    apply(9, 1, 1, 0, "R4");
    rd_all("R4");
    apply(8, 16'hFFFF, 1, 0, "R3");
    apply(11, 1, 1, 0, "R5");
    apply(12, 16'h0010, 1, 0, "R5");
    rd_all("R5");
    apply(13, 16'h00F0, 1, 0, "R6");
    apply(14, 16'h0F00, 1, 0, "R6");
    rd_all("R6");
    apply(15, 16'h8003, 1, 0, "R7");
    rd_all("R7");
    apply(8, 16'h1234, 1, 1, "R11");
    apply(8, 0, 0, 1, "R8");
    apply(16, 16'h5555, 1, 1, "R2");
    apply(7, 16'h5555, 1, 1, "R2");
    apply(8, 0, 0, 1, "R2");
    apply(9, 0, 0, 0, "R10");
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      bit w, r;
      string tag;
      a = ($urandom % 8 == 0) ? int'($urandom % 64) : 8 + int'($urandom % 8);
      d = int'($urandom % 65536);
      if ($urandom % 4 == 0) d = (($urandom % 2) == 1) ? 16'hFFFF : (($urandom % 2) == 1) ? 16'h8000 : 0;
      w = ($urandom % 2) == 1;
      r = ($urandom % 3) != 0;
      if (a < 8 || a > 15) tag = "R2";
      else if (!r) tag = "R10";
      else if (w) tag = "R11";
      else if (a == 8) tag = "R8";
      else tag = "R9";
      apply(a, d, w, r, tag);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule